// File: doc/BRIEF.md
# Same-Cycle Forwarding Register File

This block is the architectural register file of a simple in-order pipeline. It holds thirty-two general registers of a parameterised data width and has one write port and two read ports. The read ports are combinational. The write port updates storage at the rising clock edge.

The logical order inside one cycle is write first, then read. When a read port addresses the register being written in the same cycle, it returns the incoming write data and not the old stored contents. A producer in writeback can therefore feed a consumer in decode in the same cycle, with no bubble. Register zero is hardwired to zero. Writes to it are dropped, and it never forwards. Hazard detection and pipeline control sit outside this block.

Top module: `wfrf_top`

## Requirements
- R1: After the synchronous active-high reset is released, every register reads as zero on both ports until it is written.
- R2: With `wr_en` high and a non-zero `wr_idx`, `wr_data` is stored at the rising edge and read back from the next cycle onward.
- R3: Index 0 always reads as zero on both ports, and a write to index 0 changes nothing.
- R4: While `wr_en` is high with a non-zero `wr_idx`, a read port addressing `wr_idx` returns `wr_data` in that same cycle.
- R5: A read of an index other than the one being written returns the stored contents, unaffected by the write.
- R6: The two read ports work independently. They may address the same register or different registers in one cycle and each returns the correct value.
- R7: While `wr_en` is low, no register changes and no read port forwards `wr_data`.
- R8: When a write to index 0 and a read of index 0 fall in the same cycle, the read returns zero and does not forward.
- R9: Asserting reset in the middle of operation clears every register, and reset takes priority over a write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Register index to write |
| wr_data | input | WIDTH (32) | Data to write |
| rd_a_idx | input | 5 | Read port A index |
| rd_a_data | output | WIDTH (32) | Read port A data (combinational) |
| rd_b_idx | input | 5 | Read port B index |
| rd_b_data | output | WIDTH (32) | Read port B data (combinational) |

## Verification
The case that matters is a write and a read falling in the same cycle. The bench provokes it by driving a write and, in the same cycle, pointing one or both read ports at the written index. It does this across every index, including index 0. The read value is sampled before the clock edge and judged against a bench model: new data on a hit, stored data for other indices, zero for index 0. Full read-pair sweeps, writes with the enable held low, and a reset that arrives together with a write complete the picture.

// File: rtl/wfrf_pkg.sv
package wfrf_pkg;
  localparam int unsigned WFRF_DEPTH = 32;
  localparam int unsigned WFRF_WIDTH = 32;
  localparam int unsigned WFRF_NRD   = 2;
endpackage

// File: rtl/wfrf_store.sv
module wfrf_store #(
  parameter int unsigned DEPTH = wfrf_pkg::WFRF_DEPTH,
  parameter int unsigned WIDTH = wfrf_pkg::WFRF_WIDTH,
  parameter int unsigned NRD   = wfrf_pkg::WFRF_NRD,
  localparam int unsigned IW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [IW-1:0]    widx,
  input  logic [WIDTH-1:0] wdata,
  input  logic [IW-1:0]    ridx  [NRD],
  output logic [WIDTH-1:0] rdata [NRD]
);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic             wr_live;

  // entry 0 is only ever loaded by reset
  assign wr_live = we && (widx != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (wr_live) begin
      mem_q[widx] <= wdata;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rdata[p] = mem_q[ridx[p]];
  end

  // R2: an accepted write lands in the addressed entry
  p_write_lands_r2: assert property (@(posedge clk) disable iff (rst)
    wr_live |=> mem_q[$past(widx)] == $past(wdata));

  // R3: entry zero never leaves zero
  p_entry0_zero_r3: assert property (@(posedge clk) disable iff (rst)
    we && widx == '0 |=> mem_q[0] == '0);
endmodule

// File: rtl/wfrf_fwd.sv
module wfrf_fwd #(
  parameter int unsigned WIDTH = wfrf_pkg::WFRF_WIDTH,
  parameter int unsigned IW    = 5
) (
  input  logic             we,
  input  logic [IW-1:0]    widx,
  input  logic [WIDTH-1:0] wdata,
  input  logic [IW-1:0]    ridx,
  input  logic [WIDTH-1:0] stored,
  output logic [WIDTH-1:0] rdata
);
  logic hit;

  always_comb begin
    hit = we && (widx != '0) && (ridx == widx);
    if (ridx == '0)  rdata = '0;
    else if (hit)    rdata = wdata;
    else             rdata = stored;
  end
endmodule

// File: rtl/wfrf_top.sv
module wfrf_top #(
  parameter int unsigned DEPTH = wfrf_pkg::WFRF_DEPTH,
  parameter int unsigned WIDTH = wfrf_pkg::WFRF_WIDTH,
  localparam int unsigned IW   = $clog2(DEPTH),
  localparam int unsigned NRD  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IW-1:0]    wr_idx,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [IW-1:0]    rd_a_idx,
  output logic [WIDTH-1:0] rd_a_data,
  input  logic [IW-1:0]    rd_b_idx,
  output logic [WIDTH-1:0] rd_b_data
);
  logic [IW-1:0]    rd_idx  [NRD];
  logic [WIDTH-1:0] st_data [NRD];
  logic [WIDTH-1:0] rd_data [NRD];

  assign rd_idx[0] = rd_a_idx;
  assign rd_idx[1] = rd_b_idx;
  assign rd_a_data = rd_data[0];
  assign rd_b_data = rd_data[1];

  wfrf_store #(.DEPTH(DEPTH), .WIDTH(WIDTH), .NRD(NRD)) u_store (
    .clk   (clk),
    .rst   (rst),
    .we    (wr_en),
    .widx  (wr_idx),
    .wdata (wr_data),
    .ridx  (rd_idx),
    .rdata (st_data)
  );

  for (genvar p = 0; p < NRD; p++) begin : g_port
    wfrf_fwd #(.WIDTH(WIDTH), .IW(IW)) u_fwd (
      .we     (wr_en),
      .widx   (wr_idx),
      .wdata  (wr_data),
      .ridx   (rd_idx[p]),
      .stored (st_data[p]),
      .rdata  (rd_data[p])
    );

    // R3 / R8: index zero reads zero even under a write to it
    p_zero_read_r3: assert property (@(posedge clk) disable iff (rst)
      rd_idx[p] == '0 |-> rd_data[p] == '0);

    // R4: same-cycle forwarding of a live write
    p_forward_r4: assert property (@(posedge clk) disable iff (rst)
      wr_en && wr_idx != '0 && rd_idx[p] == wr_idx |-> rd_data[p] == wr_data);

    // R2: previous cycle's write is seen when not overwritten now
    p_stored_r2: assert property (@(posedge clk) disable iff (rst)
      $past(wr_en && wr_idx != '0 && !rst) && rd_idx[p] == $past(wr_idx)
      && !(wr_en && wr_idx == rd_idx[p])
      |-> rd_data[p] == $past(wr_data));

    // R1: first cycle out of reset reads zero unless forwarding
    p_reset_zero_r1: assert property (@(posedge clk) disable iff (rst)
      $past(rst) && !(wr_en && wr_idx == rd_idx[p]) |-> rd_data[p] == '0);
  end
endmodule

// File: tb/wfrf_top_bench.sv
module wfrf_top_bench;
  localparam int DW = 32;
  localparam int NR = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [4:0]    wr_idx = '0;
  logic [DW-1:0] wr_data = '0;
  logic [4:0]    rd_a_idx = '0;
  logic [DW-1:0] rd_a_data;
  logic [4:0]    rd_b_idx = '0;
  logic [DW-1:0] rd_b_data;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [DW-1:0] model [NR];

  always #4 clk = ~clk;

  wfrf_top u_wfrf_top (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data)
  );

  function automatic logic [DW-1:0] pat(int i, int salt);
    return DW'((i + 1) * 32'h9E37_79B1) ^ DW'(salt * 32'h0101_0101);
  endfunction

  function automatic logic [DW-1:0] expect_rd(int r, bit we, int w, logic [DW-1:0] d);
    if (r == 0) return '0;
    if (we && w == r) return d;
    return model[r];
  endfunction

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(bit we, int w, logic [DW-1:0] d, int a, int b, string req);
    @(negedge clk);
    wr_en = we; wr_idx = 5'(w); wr_data = d;
    rd_a_idx = 5'(a); rd_b_idx = 5'(b);
    #1;
    check(req, rd_a_data, expect_rd(a, we, w, d));
    check(req, rd_b_data, expect_rd(b, we, w, d));
    @(posedge clk);
    if (we && w != 0) model[w] = d;
  endtask

  task automatic do_reset(bit we, int w, logic [DW-1:0] d);
    @(negedge clk);
    rst = 1'b1; wr_en = we; wr_idx = 5'(w); wr_data = d;
    @(posedge clk);
    for (int i = 0; i < NR; i++) model[i] = '0;
    @(negedge clk);
    rst = 1'b0; wr_en = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < NR; i++) model[i] = '0;
    do_reset(1'b0, 0, '0);
    // R1: everything reads zero after reset
    for (int i = 0; i < NR; i++) cyc(1'b0, 0, '0, i, NR - 1 - i, "R1");
    // R4 / R5 / R8: write each index, port A forwards, port B reads neighbour
    for (int i = 0; i < NR; i++)
      cyc(1'b1, i, pat(i, 1), i, (i + 7) % NR, i == 0 ? "R8" : "R4");
    // R2 / R3 / R6: every read pair after the fill
    for (int a = 0; a < NR; a++)
      for (int b = 0; b < NR; b++)
        cyc(1'b0, 0, '0, a, b, a == b ? "R6" : "R2");
    // R4 / R6: both ports on the written index; overwrite with new salt
    for (int i = 1; i < NR; i++) cyc(1'b1, i, pat(i, 2), i, i, "R4");
    // R5: read other index while writing
    for (int i = 1; i < NR; i++) cyc(1'b1, i, pat(i, 3), (i % 31) + 1, 0, "R5");
    // R7: enable low, attempted data must not forward or land
    for (int i = 1; i < NR; i++) cyc(1'b0, i, ~pat(i, 9), i, i, "R7");
    for (int i = 0; i < NR; i++) cyc(1'b0, 0, '0, i, i, "R7");
    // R3: write to zero with nonzero data, read zero
    cyc(1'b1, 0, 32'hFFFF_FFFF, 0, 0, "R3");
    cyc(1'b0, 0, '0, 0, 0, "R3");
    // R9: reset during a write clears everything
    do_reset(1'b1, 5, 32'hDEAD_BEEF);
    for (int i = 0; i < NR; i++) cyc(1'b0, 0, '0, i, (i + 1) % NR, "R9");
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      done = 1'b1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule